// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block turns a reference clock into an audio master clock whose frequency is a chosen multiple of the sample rate fs. The reference clock `clk_i` runs at twice the internal serial-audio rate. The serial-audio rate is set by a family select. With `base_sel_i` = 0 the serial rate is 512·fs, so `clk_i` is 1024·fs. With `base_sel_i` = 1 the serial rate is 384·fs, so `clk_i` is 768·fs. A 3-bit ratio code k divides the serial rate by 2^k. The output therefore covers 512/256/128/64/32·fs in one family and 384/192/96/48·fs in the other.

A free-running counter advances on every `clk_i` edge while the generator runs. Bit k of that counter drives the output, so the duty cycle is 50 %. The configuration is written with a one-cycle strobe and is accepted only while the generator is idle. A run level starts and stops the output. When run is dropped, the output finishes its current high phase and then parks low, so no shortened pulse appears. A freeze input holds every piece of state. A synchronous soft reset forces everything back to its reset values for as long as it is held.

Top module: `mclk_ratio_gen`

## Requirements
- R1: After `rst_ni` is released, `mclk_o`, `mclk_oe_o`, `busy_o` and `cfg_err_o` are 0. The stored configuration is family 512 with ratio code 0.
- R2: With `base_sel_i`=0, ratio codes 0,1,2,3,4 give 512,256,128,64,32·fs. The `mclk_o` period is 2^(k+1) cycles of `clk_i` (`clk_i` = 1024·fs).
- R3: With `base_sel_i`=1, ratio codes 0,1,2,3 give 384,192,96,48·fs. The `mclk_o` period is 2^(k+1) cycles of `clk_i` (`clk_i` = 768·fs).
- R4: Ratio codes 5..7 with `base_sel_i`=0, and 4..7 with `base_sel_i`=1, are illegal. They raise `cfg_err_o` one cycle after the write. While `cfg_err_o` is 1, `run_i` is ignored: `busy_o` and `mclk_o` stay 0.
- R5: While running, `mclk_o` is high for exactly 2^k cycles of each 2^(k+1)-cycle period.
- R6: `mclk_o` toggles only while running. `busy_o` and `mclk_oe_o` go to 1 on the first clock edge that samples `run_i`=1 with a legal configuration. With `run_i`=0 and idle, `mclk_o` stays 0.
- R7: When `run_i` drops, the current high phase completes at its full 2^k-cycle width. On the edge where `mclk_o` falls, `busy_o` and `mclk_oe_o` fall with it, and `mclk_o` then stays 0.
- R8: While `gate_i`=1 (and no soft reset), `mclk_o`, `busy_o` and the stored configuration hold their values. Changes on `cfg_we_i` and `run_i` have no effect.
- R9: A configuration write while `busy_o`=1 is ignored. The running period does not change, and the write has no effect after the generator stops.
- R10: While `soft_rst_i`=1, all state returns to its R1 values one edge later and stays there, with priority over `gate_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the serial-audio rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, held while 1 |
| gate_i | input | 1 | Freeze: holds all state while 1 |
| cfg_we_i | input | 1 | Configuration write strobe |
| base_sel_i | input | 1 | Family: 0 = 512·fs base, 1 = 384·fs base |
| ratio_i | input | 3 | Ratio code k, divide base by 2^k |
| run_i | input | 1 | Run level |
| mclk_o | output | 1 | Master clock output |
| mclk_oe_o | output | 1 | Pad output enable for the master clock |
| busy_o | output | 1 | Generator active, so configuration is locked |
| cfg_err_o | output | 1 | Stored configuration is illegal |

## Verification
The bench uses the default parameters: ratio limits of 4 for the 512 family and 3 for the 384 family, which give a 5-bit counter. Every legal code of both families is reachable, as are the illegal codes just above each limit and a code at the top of the field. The slowest setting is a 32-cycle period, which exercises a full counter wrap. A stop in mid high phase, a freeze with a write underneath it, and a write while busy are reached with a few hundred cycles each.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int unsigned RATIO_W = 3;

  typedef struct packed {
    logic               base_sel;
    logic [RATIO_W-1:0] ratio;
  } mclk_cfg_t;

  function automatic logic cfg_illegal(mclk_cfg_t c, int unsigned max512, int unsigned max384);
    int unsigned lim;
    lim = c.base_sel ? max384 : max512;
    return (int'(c.ratio) > int'(lim));
  endfunction
endpackage

// File: rtl/mclk_cfg_reg.sv
module mclk_cfg_reg
  import mclk_pkg::*;
#(
  parameter int unsigned MAX_RATIO_512 = 4,
  parameter int unsigned MAX_RATIO_384 = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      hold_i,
  input  logic      busy_i,
  input  logic      we_i,
  input  mclk_cfg_t cfg_i,
  output mclk_cfg_t cfg_o,
  output logic      err_o
);
  mclk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (clr_i)                       cfg_q <= '0;
    else if (we_i && !hold_i && !busy_i)  cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
  assign err_o = cfg_illegal(cfg_q, MAX_RATIO_512, MAX_RATIO_384);
endmodule

// File: rtl/mclk_div_cnt.sv
module mclk_div_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (!hold_i && en_i) cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mclk_out_ctl.sv
module mclk_out_ctl
  import mclk_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               hold_i,
  input  logic               run_i,
  input  logic               cfg_err_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   cnt_nxt_i,
  output logic               en_o,
  output logic               stop_o,
  output logic               mclk_o
);
  logic en_q;
  logic cur_bit, nxt_bit;

  // tap selected by ratio code; codes beyond the counter read as 0
  always_comb begin
    cur_bit = 1'b0;
    nxt_bit = 1'b0;
    for (int i = 0; i < int'(CNT_W); i++) begin
      if (int'(ratio_i) == i) begin
        cur_bit = cnt_i[i];
        nxt_bit = cnt_nxt_i[i];
      end
    end
  end

  // stop only where the tap is (or is about to be) low: no runt high pulse
  assign stop_o = en_q && !hold_i && !run_i && !nxt_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               en_q <= 1'b0;
    else if (clr_i)                            en_q <= 1'b0;
    else if (hold_i)                           en_q <= en_q;
    else if (!en_q && run_i && !cfg_err_i)     en_q <= 1'b1;
    else if (stop_o)                           en_q <= 1'b0;
  end

  assign en_o   = en_q;
  assign mclk_o = en_q & cur_bit;
endmodule

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen
  import mclk_pkg::*;
#(
  parameter int unsigned MAX_RATIO_512 = 4,
  parameter int unsigned MAX_RATIO_384 = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               gate_i,
  input  logic               cfg_we_i,
  input  logic               base_sel_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               run_i,
  output logic               mclk_o,
  output logic               mclk_oe_o,
  output logic               busy_o,
  output logic               cfg_err_o
);
  localparam int unsigned MAX_RATIO = (MAX_RATIO_512 > MAX_RATIO_384) ? MAX_RATIO_512 : MAX_RATIO_384;
  localparam int unsigned CNT_W     = MAX_RATIO + 1;

  mclk_cfg_t        cfg_in, cfg_q;
  logic             cfg_err;
  logic             en, stop;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign cfg_in = '{base_sel: base_sel_i, ratio: ratio_i};

  mclk_cfg_reg #(
    .MAX_RATIO_512(MAX_RATIO_512),
    .MAX_RATIO_384(MAX_RATIO_384)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .hold_i (gate_i),
    .busy_i (en),
    .we_i   (cfg_we_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q),
    .err_o  (cfg_err)
  );

  mclk_div_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i | stop),
    .hold_i    (gate_i),
    .en_i      (en),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  mclk_out_ctl #(.CNT_W(CNT_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .hold_i    (gate_i),
    .run_i     (run_i),
    .cfg_err_i (cfg_err),
    .ratio_i   (cfg_q.ratio),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .en_o      (en),
    .stop_o    (stop),
    .mclk_o    (mclk_o)
  );

  assign mclk_oe_o = en;
  assign busy_o    = en;
  assign cfg_err_o = cfg_err;
endmodule

// File: rtl/mclk_ratio_gen_chk.sv
module mclk_ratio_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic gate_i,
  input logic run_i,
  input logic mclk_o,
  input logic busy_o,
  input logic cfg_err_o
);
  assert_err_blocks_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);

  assert_idle_stays_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !busy_o) |=> !busy_o);

  assert_stop_parks_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !mclk_o);

  assert_freeze_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !soft_rst_i) |=> ($stable(mclk_o) && $stable(busy_o) && $stable(cfg_err_o)));

  assert_cfg_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !soft_rst_i) |=> $stable(cfg_err_o));

  assert_soft_reset_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!mclk_o && !busy_o && !cfg_err_o));
endmodule

bind mclk_ratio_gen mclk_ratio_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .gate_i     (gate_i),
  .run_i      (run_i),
  .mclk_o     (mclk_o),
  .busy_o     (busy_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/tb_mclk_ratio_gen.sv
module tb_mclk_ratio_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // family base (x fs), ratio code, expected multiple (0 = illegal)
  localparam int VB [NV] = '{512, 512, 512, 512, 512, 512, 512, 384, 384, 384, 384, 384, 384};
  localparam int VF [NV] = '{0,   1,   2,   3,   4,   5,   7,   0,   1,   2,   3,   4,   6};
  localparam int VM [NV] = '{512, 256, 128, 64,  32,  0,   0,   384, 192, 96,  48,  0,   0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, gate = 1'b0, cfg_we = 1'b0, base_sel = 1'b0, run = 1'b0;
  logic [2:0] ratio = '0;
  logic       mclk, mclk_oe, busy, cfg_err;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_ratio_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .gate_i(gate),
    .cfg_we_i(cfg_we), .base_sel_i(base_sel), .ratio_i(ratio), .run_i(run),
    .mclk_o(mclk), .mclk_oe_o(mclk_oe), .busy_o(busy), .cfg_err_o(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic b, input logic [2:0] f);
    @(negedge clk); cfg_we = 1'b1; base_sel = b; ratio = f;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // returns with the current negedge sample being the first high sample
  task automatic wait_rise(output int ok);
    logic prev;
    ok = 0;
    prev = mclk;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mclk && !prev) begin ok = 1; break; end
      prev = mclk;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    per = 1; hi = 1; prev = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mclk && !prev) break;
      per++;
      if (mclk) hi++;
      prev = mclk;
    end
  endtask

  task automatic low_window(input int n, output int highs, output int busies);
    highs = 0; busies = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk) highs++;
      if (busy) busies++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ok, per, hi, hs, bs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mclk", mclk, 0);
    check("R1 oe", mclk_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 cfg_err", cfg_err, 0);
    // R6 idle without run
    low_window(40, hs, bs);
    check("R6 idle mclk highs", hs, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      run = 1'b0;
      wait_idle();
      set_cfg(VB[v] == 384, 3'(VF[v]));
      @(negedge clk); run = 1'b1;
      if (VM[v] != 0) begin
        @(negedge clk);
        check("R6 busy after run", busy, 1);
        check("R6 oe after run", mclk_oe, 1);
        wait_rise(ok);
        check("R6 mclk rises", ok, 1);
        measure(per, hi);
        check(VB[v] == 512 ? "R2 period" : "R3 period", per, 2 * VB[v] / VM[v]);
        check("R5 high width", hi * 2, per);
        check("R4 no err on legal", cfg_err, 0);
      end else begin
        low_window(40, hs, bs);
        check("R4 cfg_err", cfg_err, 1);
        check("R4 mclk stays low", hs, 0);
        check("R4 busy stays low", bs, 0);
      end
    end

    // R7 stop mid high phase (512 family, code 3: high 8 cycles)
    run = 1'b0; wait_idle();
    set_cfg(1'b0, 3'd3);
    @(negedge clk); run = 1'b1;
    wait_rise(ok);
    hi = 1;
    repeat (2) begin @(negedge clk); if (mclk) hi++; end
    run = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!mclk) break;
      hi++;
    end
    check("R7 full last high", hi, 8);
    check("R7 busy falls with mclk", busy, 0);
    check("R7 oe falls with mclk", mclk_oe, 0);
    low_window(40, hs, bs);
    check("R7 stays low", hs, 0);

    // R8 freeze while running: output held, run drop ignored
    set_cfg(1'b0, 3'd2);
    @(negedge clk); run = 1'b1;
    wait_rise(ok);
    gate = 1'b1; run = 1'b0;
    hs = 0; bs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mclk) hs++;
      if (busy) bs++;
    end
    check("R8 mclk frozen high", hs, 20);
    check("R8 busy frozen", bs, 20);
    gate = 1'b0;
    wait_idle();
    // R8 write under freeze ignored
    gate = 1'b1;
    set_cfg(1'b0, 3'd6);
    @(negedge clk); gate = 1'b0;
    @(negedge clk);
    check("R8 write ignored under gate", cfg_err, 0);

    // R9 write while busy ignored (512 code 1: period 4)
    set_cfg(1'b0, 3'd1);
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    set_cfg(1'b0, 3'd4);
    wait_rise(ok);
    measure(per, hi);
    check("R9 period unchanged", per, 4);
    run = 1'b0; wait_idle();
    @(negedge clk); run = 1'b1;
    wait_rise(ok);
    measure(per, hi);
    check("R9 write not applied later", per, 4);

    // R10 soft reset while running, priority over gate
    set_cfg(1'b0, 3'd1);
    @(negedge clk); soft_rst = 1'b1; gate = 1'b1;
    low_window(5, hs, bs);
    check("R10 mclk held low", hs, 0);
    check("R10 busy held low", bs, 0);
    gate = 1'b0; soft_rst = 1'b0; run = 1'b0;
    @(negedge clk);
    set_cfg(1'b1, 3'd5);
    @(negedge clk);
    check("R4 illegal 384 code 5", cfg_err, 1);
    soft_rst = 1'b1;
    @(negedge clk);
    check("R10 cfg_err cleared", cfg_err, 0);
    soft_rst = 1'b0;
    // R10 back to default: 512 code 0, period 2
    @(negedge clk); run = 1'b1;
    wait_rise(ok);
    measure(per, hi);
    check("R10 default cfg period", per, 2);
    run = 1'b0;
    wait_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule